// File: doc/BRIEF.md
# USB Device Command Register

This block is the device-mode command register of a USB device controller. Software writes it through a simple single-register write port and reads it back combinationally. It holds four live fields. The first is a run/stop control that drives the data-plus pull-up enable. The second is a controller-reset request that clears itself when the controller finishes its reset. The last two are software semaphores, called trip wires, that the endpoint logic knocks down when a hazard occurs.

The pull-up is not a plain copy of run/stop. A state machine with three states sets it. `PU_DETACHED` has the pull-up off. `PU_ATTACH_FS` has it on. `PU_HS_RELEASED` has run/stop set but the pull-up off, because the link has entered high-speed mode. Its transitions are:
- It goes to `PU_DETACHED` whenever run/stop is 0.
- It goes to `PU_ATTACH_FS` when run/stop is 1 and high-speed mode is off.
- It goes to `PU_HS_RELEASED` when run/stop is 1 and high-speed mode is on.

The reset machine has two states, `CR_IDLE` and `CR_BUSY`. It goes from idle to busy when software writes 1 to the reset bit. It returns from busy to idle only on a reset-done pulse. Each trip wire is a two-state machine, `TW_DOWN` and `TW_ARMED`. A software write sets either state. A hardware hazard forces `TW_DOWN`.

Top module: `usb_dev_cmd_reg`

## Requirements
- R1: After reset, the readback is 0, the pull-up enable is 0 and the reset request is 0.
- R2: Bit 0 is run/stop. A write stores bit 0 of the write data, and the readback shows it from the next cycle.
- R3: With high-speed mode off, the pull-up enable equals the run/stop value held one cycle earlier. Setting run/stop attaches the device and clearing it detaches the device.
- R4: While high-speed mode is 1, the pull-up enable is 0 on the following cycle, even if run/stop stays 1.
- R5: A write with bit 1 set makes readback bit 1 and the reset request output 1 from the next cycle. Both stay 1 until a reset-done pulse, and both are 0 the cycle after that pulse.
- R6: While a reset is in progress, a write with bit 1 clear does not end it.
- R7: Bit 13 is the setup trip wire, and software can write it to 1 or 0. A setup-arrival hazard with lockout mode 0 clears it.
- R8: With lockout mode 1, a setup-arrival hazard leaves bit 13 unchanged.
- R9: Bit 14 is the add-descriptor trip wire, and software can write it to 1 or 0. A descriptor hazard from the endpoint logic clears it.
- R10: When a hazard clear and a software write of 1 to the same trip wire happen in the same cycle, the bit reads 0 afterwards.
- R11: Every bit other than 0, 1, 13 and 14 reads 0, whatever has been written to it.
- R12: A reset-done pulse while no reset is in progress changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register readback |
| hs_mode | input | 1 | Link is in high-speed mode |
| setup_lockout | input | 1 | Setup lockout mode from the mode register (static) |
| setup_hazard | input | 1 | New setup data arrived while the payload may be in use |
| dtd_hazard | input | 1 | Endpoint machine is in the add-descriptor hazard window |
| ctrl_reset_done | input | 1 | One-cycle pulse: the controller reset has finished |
| ctrl_reset_req | output | 1 | Controller reset request, high while a reset is in progress |
| pullup_en | output | 1 | Data-plus pull-up enable |

## Verification
The assertions assume that `ctrl_reset_done` is a pulse the controller may raise at any time. A pulse that arrives outside a reset must be harmless. The assertions also assume that `setup_lockout` changes only between operations, never in the same cycle as a setup hazard. The stimulus drives every input at the falling edge and only changes lockout on cycles with no setup hazard. Done pulses and hazards are drawn at random, including in cycles where software writes the affected bits, so the priority cases are reached on purpose.

// File: rtl/usb_cmd_pkg.sv
package usb_cmd_pkg;

    localparam int CMD_W        = 32;
    localparam int RUN_POS      = 0;
    localparam int CRST_POS     = 1;
    localparam int SETUP_TW_POS = 13;
    localparam int ADD_TW_POS   = 14;

    typedef enum logic [1:0] {
        PU_DETACHED    = 2'd0,
        PU_ATTACH_FS   = 2'd1,
        PU_HS_RELEASED = 2'd2
    } pu_state_t;

    typedef enum logic {
        CR_IDLE = 1'b0,
        CR_BUSY = 1'b1
    } crst_state_t;

    typedef enum logic {
        TW_DOWN  = 1'b0,
        TW_ARMED = 1'b1
    } tw_state_t;

endpackage

// File: rtl/dev_pullup_fsm.sv
module dev_pullup_fsm
    import usb_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_stop,
    input  logic hs_mode,
    output logic pullup_en
);

    pu_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PU_DETACHED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PU_DETACHED: begin
                if (run_stop) state_d = hs_mode ? PU_HS_RELEASED : PU_ATTACH_FS;
            end
            PU_ATTACH_FS: begin
                if (!run_stop)   state_d = PU_DETACHED;
                else if (hs_mode) state_d = PU_HS_RELEASED;
            end
            PU_HS_RELEASED: begin
                if (!run_stop)     state_d = PU_DETACHED;
                else if (!hs_mode) state_d = PU_ATTACH_FS;
            end
            default: state_d = PU_DETACHED;
        endcase
    end

    always_comb begin
        pullup_en = (state_q == PU_ATTACH_FS);
    end

    AST_PU_HS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        hs_mode |=> !pullup_en); // R4
    AST_PU_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
        !run_stop |=> !pullup_en); // R3
    AST_PU_ATTACH: assert property (@(posedge clk) disable iff (!rst_n)
        (run_stop && !hs_mode) |=> pullup_en); // R3

endmodule

// File: rtl/dev_crst_fsm.sv
module dev_crst_fsm
    import usb_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic done,
    output logic busy
);

    crst_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CR_IDLE: if (start_req) state_d = CR_BUSY;
            CR_BUSY: if (done)      state_d = CR_IDLE;
            default: state_d = CR_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == CR_BUSY);
    end

    AST_CRST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> busy); // R5
    AST_CRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R6
    AST_CRST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy); // R5
    AST_CRST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_req && done) |=> !busy); // R12

endmodule

// File: rtl/dev_tripwire.sv
module dev_tripwire
    import usb_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_we,
    input  logic sw_val,
    input  logic hw_clr,
    output logic armed
);

    tw_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TW_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TW_DOWN:  if (sw_we && sw_val && !hw_clr) state_d = TW_ARMED;
            TW_ARMED: if (hw_clr || (sw_we && !sw_val)) state_d = TW_DOWN;
            default:  state_d = TW_DOWN;
        endcase
    end

    always_comb begin
        armed = (state_q == TW_ARMED);
    end

    AST_TW_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr |=> !armed); // R10
    AST_TW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_clr && !sw_we) |=> (armed == $past(armed))); // R7

endmodule

// File: rtl/usb_dev_cmd_reg.sv
module usb_dev_cmd_reg
    import usb_cmd_pkg::*;
#(
    parameter int DATA_W   = CMD_W,
    parameter int RUN_B    = RUN_POS,
    parameter int CRST_B   = CRST_POS,
    parameter int SETUP_B  = SETUP_TW_POS,
    parameter int ADD_B    = ADD_TW_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hs_mode,
    input  logic              setup_lockout,
    input  logic              setup_hazard,
    input  logic              dtd_hazard,
    input  logic              ctrl_reset_done,
    output logic              ctrl_reset_req,
    output logic              pullup_en
);

    localparam int TW_N = 2;
    localparam logic [DATA_W-1:0] LIVE_MASK =
        (DATA_W'(1) << RUN_B) | (DATA_W'(1) << CRST_B) |
        (DATA_W'(1) << SETUP_B) | (DATA_W'(1) << ADD_B);

    logic            run_q;
    logic            crst_busy;
    logic [TW_N-1:0] tw_clr;
    logic [TW_N-1:0] tw_val;
    logic [TW_N-1:0] tw_armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_q <= 1'b0;
        else if (wr_en) run_q <= wr_data[RUN_B];
    end

    dev_pullup_fsm i_pullup (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_stop  (run_q),
        .hs_mode   (hs_mode),
        .pullup_en (pullup_en)
    );

    dev_crst_fsm i_crst (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (wr_en && wr_data[CRST_B]),
        .done      (ctrl_reset_done),
        .busy      (crst_busy)
    );

    assign ctrl_reset_req = crst_busy;

    assign tw_clr[0] = setup_hazard && !setup_lockout;
    assign tw_clr[1] = dtd_hazard;
    assign tw_val[0] = wr_data[SETUP_B];
    assign tw_val[1] = wr_data[ADD_B];

    for (genvar g = 0; g < TW_N; g++) begin : g_tw
        dev_tripwire i_tw (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_we  (wr_en),
            .sw_val (tw_val[g]),
            .hw_clr (tw_clr[g]),
            .armed  (tw_armed[g])
        );
    end

    always_comb begin
        rd_data          = '0;
        rd_data[RUN_B]   = run_q;
        rd_data[CRST_B]  = crst_busy;
        rd_data[SETUP_B] = tw_armed[0];
        rd_data[ADD_B]   = tw_armed[1];
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && |(wr_data & ~LIVE_MASK)) |=> ((rd_data & ~LIVE_MASK) == '0)); // R11
    AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[RUN_B] == $past(wr_data[RUN_B]))); // R2
    AST_SETUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_hazard && !setup_lockout) |=> !rd_data[SETUP_B]); // R7
    AST_SETUP_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_hazard && setup_lockout && !wr_en) |=> (rd_data[SETUP_B] == $past(rd_data[SETUP_B]))); // R8
    AST_ADD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        dtd_hazard |=> !rd_data[ADD_B]); // R9

endmodule

// File: tb/test_usb_dev_cmd_reg.sv
`timescale 1ns/1ps
module test_usb_dev_cmd_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        hs_mode = 1'b0;
    logic        setup_lockout = 1'b0;
    logic        setup_hazard = 1'b0;
    logic        dtd_hazard = 1'b0;
    logic        ctrl_reset_done = 1'b0;
    logic        ctrl_reset_req;
    logic        pullup_en;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    usb_dev_cmd_reg i_usb_dev_cmd_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .hs_mode(hs_mode), .setup_lockout(setup_lockout),
        .setup_hazard(setup_hazard), .dtd_hazard(dtd_hazard),
        .ctrl_reset_done(ctrl_reset_done), .ctrl_reset_req(ctrl_reset_req),
        .pullup_en(pullup_en)
    );

    // behavioural reference model
    int m_run = 0, m_rst = 0, m_pu = 0, m_sw = 0, m_aw = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_rst = 0; m_pu = 0; m_sw = 0; m_aw = 0;
        end else begin
            m_pu = (m_run == 1 && !hs_mode) ? 1 : 0;
            if (m_rst == 1) begin
                if (ctrl_reset_done) m_rst = 0;
            end else if (wr_en && wr_data[1]) m_rst = 1;
            if (setup_hazard && !setup_lockout) m_sw = 0;
            else if (wr_en) m_sw = wr_data[13];
            if (dtd_hazard) m_aw = 0;
            else if (wr_en) m_aw = wr_data[14];
            if (wr_en) m_run = wr_data[0];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            logic [31:0] e;
            e = '0;
            e[0] = m_run[0]; e[1] = m_rst[0]; e[13] = m_sw[0]; e[14] = m_aw[0];
            chk(rd_data[0] == e[0], "R2 run bit", {31'b0, rd_data[0]}, {31'b0, e[0]});
            chk(rd_data[1] == e[1], "R5/R6 reset bit", {31'b0, rd_data[1]}, {31'b0, e[1]});
            chk(ctrl_reset_req == e[1], "R5 reset req", {31'b0, ctrl_reset_req}, {31'b0, e[1]});
            chk(rd_data[13] == e[13], "R7 setup tw", {31'b0, rd_data[13]}, {31'b0, e[13]});
            chk(rd_data[14] == e[14], "R9 add tw", {31'b0, rd_data[14]}, {31'b0, e[14]});
            chk((rd_data & ~32'h6003) == 0, "R11 reserved", rd_data, e);
            chk(pullup_en == m_pu[0], "R3/R4 pullup", {31'b0, pullup_en}, {31'b0, m_pu[0]});
        end
    end

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk(rd_data == 0 && !pullup_en && !ctrl_reset_req, "R1 reset state", rd_data, 0);

        wr(32'h1);
        idle(1);
        chk(pullup_en == 1'b1, "R3 attach", {31'b0, pullup_en}, 1);
        hs_mode = 1'b1; idle(1);
        chk(pullup_en == 1'b0 && rd_data[0], "R4 hs drop", {31'b0, pullup_en}, 0);
        hs_mode = 1'b0; idle(1);
        chk(pullup_en == 1'b1, "R3 reattach", {31'b0, pullup_en}, 1);

        wr(32'h2);
        chk(ctrl_reset_req == 1'b1 && rd_data[1], "R5 reset start", rd_data, 32'h2);
        wr(32'h0);
        chk(ctrl_reset_req == 1'b1, "R6 no abort", {31'b0, ctrl_reset_req}, 1);
        idle(1);
        chk(pullup_en == 1'b0, "R3 detach", {31'b0, pullup_en}, 0);
        ctrl_reset_done = 1'b1; idle(1); ctrl_reset_done = 1'b0;
        chk(ctrl_reset_req == 1'b0 && !rd_data[1], "R5 reset end", rd_data, 0);
        ctrl_reset_done = 1'b1; idle(1); ctrl_reset_done = 1'b0;
        chk(rd_data == 0 && !ctrl_reset_req, "R12 idle done", rd_data, 0);

        wr(32'h6000);
        chk(rd_data == 32'h6000, "R7 R9 set", rd_data, 32'h6000);
        setup_lockout = 1'b1; idle(1);
        setup_hazard = 1'b1; idle(1); setup_hazard = 1'b0;
        chk(rd_data[13] == 1'b1, "R8 lockout", rd_data, 32'h6000);
        setup_lockout = 1'b0; idle(1);
        setup_hazard = 1'b1; idle(1); setup_hazard = 1'b0;
        chk(rd_data[13] == 1'b0, "R7 hw clear", rd_data, 32'h4000);
        dtd_hazard = 1'b1; idle(1); dtd_hazard = 1'b0;
        chk(rd_data[14] == 1'b0, "R9 hw clear", rd_data, 0);
        dtd_hazard = 1'b1; setup_hazard = 1'b1; wr(32'h6000);
        dtd_hazard = 1'b0; setup_hazard = 1'b0;
        chk(rd_data[14:13] == 2'b00, "R10 hw wins", rd_data, 0);

        wr(32'hFFFF_FFFF);
        chk(rd_data == 32'h6003, "R11 reserved", rd_data, 32'h6003);
        ctrl_reset_done = 1'b1; idle(1); ctrl_reset_done = 1'b0;

        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom_range(0, 3) == 0);
            wr_data = $urandom;
            hs_mode = ($urandom_range(0, 7) == 0) ? ~hs_mode : hs_mode;
            setup_hazard = ($urandom_range(0, 5) == 0);
            if (!setup_hazard && $urandom_range(0, 15) == 0) setup_lockout = ~setup_lockout;
            dtd_hazard = ($urandom_range(0, 5) == 0);
            ctrl_reset_done = ($urandom_range(0, 9) == 0);
            @(negedge clk);
        end
        wr_en = 1'b0; setup_hazard = 1'b0; dtd_hazard = 1'b0; ctrl_reset_done = 1'b0;
        idle(2);
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule